// File: doc/BRIEF.md
# Wide Pipelined CRC-32 Engine

This block computes a 32-bit cyclic redundancy remainder over a message of any length. It accepts one 256-bit word in every clock cycle. The message is treated as a polynomial over GF(2), with its first bit as the highest-order coefficient. The result is that polynomial times x^32, reduced modulo the generator 0x04C11DB7 (x^32 + x^26 + x^23 + x^22 + x^16 + x^12 + x^11 + x^10 + x^8 + x^7 + x^5 + x^4 + x^2 + x + 1). The running remainder starts at zero, and no inversion or bit reflection is applied.

Each word is cut into eight 32-bit chunks. Every chunk is folded into its contribution by byte lanes, all in the same cycle, and the eight contributions are combined with XOR. Only the merge of the previous remainder into the current word's contribution closes a loop. That merge is a fixed 32-bit GF(2) matrix step, so the width of the word does not lengthen the loop. The caller marks the first word with a start flag and the last word with an end flag. The last word also carries a byte count, so the total length never has to be known in advance.

A small controller in the loop stage has two states. `ST_IDLE` means no message is open. `ST_BUSY` means a message is open. The transitions are:
- IDLE to BUSY: a start word that is not also an end word.
- IDLE to IDLE: a start-and-end word, which is a single-word message.
- BUSY to BUSY: a middle word, or a start word that is not an end word, which restarts the message.
- BUSY to IDLE: any end word.

In IDLE, words without a start flag are dropped.

Top module: `crc_wide_pipe`

## Requirements
- R1: The result equals M(x)·x^32 mod G(x), where G is 0x04C11DB7, the message bits are taken most significant first (bit 255 of `in_data` is the first bit of a word), the initial remainder is zero and no output inversion is applied. A message made of the single byte 0x01 gives 0x04C11DB7.
- R2: One word is accepted in every cycle in which `in_valid` is high. Messages of any number of words may follow each other with no idle cycle between them, and each one produces its own result, in order.
- R3: On an end word, `in_len` gives the number of valid bytes. A value k from 1 to 31 means the top k bytes (starting at bits 255:248) are valid, and 0 means all 32 are valid. The bytes below the valid ones do not change the result.
- R4: A word with `in_start` high begins a new message whose running remainder is zero. A word with both `in_start` and `in_end` high is a complete single-word message.
- R5: A start word that arrives while a message is open abandons that message. Only the new message produces a result.
- R6: A valid word without `in_start` that arrives while no message is open is ignored, and it produces no `crc_done` pulse.
- R7: `crc_done` is high for one cycle, with the matching `crc_out`. This happens after the third rising edge, counting the edge that samples the end word as the first.
- R8: `crc_out` keeps its value in every cycle in which `crc_done` is low.
- R9: Cycles in which `in_valid` is low may fall between the words of a message without changing its result. In those cycles `in_start`, `in_end`, `in_data` and `in_len` are ignored.
- R10: While `rst_n` is low, `crc_done` is low, `crc_out` is zero and no message is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is presented this cycle |
| in_start | input | 1 | The word is the first of a message |
| in_end | input | 1 | The word is the last of a message |
| in_data | input | 256 | Message word, first bit at bit 255 |
| in_len | input | 5 | Valid bytes in an end word, 0 meaning 32 |
| crc_out | output | 32 | Remainder of the last completed message |
| crc_done | output | 1 | One-cycle pulse marking a new `crc_out` |

## Verification
The hardest case to reach is a multi-word message whose last word holds only one to three bytes. In that case the carried remainder is wider than the valid tail, so it has to be advanced by fewer bits than its own width rather than folded into the word. The stimulus drives messages of 33, 66 and 99 bytes with random filler in the invalid bytes. It also inserts idle gaps, during which the control inputs are held at their most disruptive values. Abandoned messages and stray words in the idle state come just before complete messages, so any leak of an earlier remainder shows up in the next result.

// File: rtl/crc_wide_pkg.sv
package crc_wide_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } msg_state_e;

    localparam int MAX_W = 64;

    // Multiply a residue by x and reduce it modulo the generator of degree width.
    function automatic logic [MAX_W-1:0] gf_mulx(input logic [MAX_W-1:0] v,
                                                 input logic [MAX_W-1:0] poly,
                                                 input int width);
        logic [MAX_W-1:0] mask;
        logic             top;
        mask = (width >= MAX_W) ? '1 : ((MAX_W'(1) << width) - MAX_W'(1));
        top  = v[width-1];
        return ((v << 1) ^ (top ? poly : '0)) & mask;
    endfunction

endpackage

// File: rtl/crc_wide_fold.sv
module crc_wide_fold
    import crc_wide_pkg::*;
#(
    parameter int              CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
    parameter int              POS   = 0
) (
    input  logic [CRC_W-1:0] chunk,
    output logic [CRC_W-1:0] part
);
    localparam int LANES = CRC_W / 8;

    typedef logic [CRC_W-1:0][CRC_W-1:0] col_tab_t;

    // Column b holds x^(POS + b + CRC_W) mod G.
    function automatic col_tab_t build_cols();
        col_tab_t         t;
        logic [MAX_W-1:0] v;
        v = MAX_W'(1);
        for (int i = 0; i < POS + CRC_W; i++) begin
            v = gf_mulx(v, MAX_W'(POLY), CRC_W);
        end
        for (int b = 0; b < CRC_W; b++) begin
            t[b] = v[CRC_W-1:0];
            v    = gf_mulx(v, MAX_W'(POLY), CRC_W);
        end
        return t;
    endfunction

    localparam col_tab_t COLS = build_cols();

    logic [LANES-1:0][CRC_W-1:0] lane_sum;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [CRC_W-1:0] lane_acc;
        always_comb begin
            lane_acc = '0;
            for (int i = 0; i < 8; i++) begin
                if (chunk[8*j+i]) begin
                    lane_acc = lane_acc ^ COLS[8*j+i];
                end
            end
        end
        assign lane_sum[j] = lane_acc;
    end

    always_comb begin
        part = '0;
        for (int j = 0; j < LANES; j++) begin
            part = part ^ lane_sum[j];
        end
    end

endmodule

// File: rtl/crc_wide_advance.sv
module crc_wide_advance
    import crc_wide_pkg::*;
#(
    parameter int               CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY  = 32'h04C11DB7,
    parameter int               STEPS = 32,
    localparam int              SEL_W = $clog2(STEPS) + 1
) (
    input  logic [CRC_W-1:0] rem,
    input  logic [SEL_W-1:0] nbytes,
    output logic [CRC_W-1:0] res
);
    typedef logic [STEPS-1:0][CRC_W-1:0][CRC_W-1:0] adv_tab_t;

    // Entry [s][b] holds x^(b + 8*(s+1)) mod G.
    function automatic adv_tab_t build_adv();
        adv_tab_t         t;
        logic [MAX_W-1:0] v;
        for (int b = 0; b < CRC_W; b++) begin
            v = MAX_W'(1) << b;
            for (int s = 0; s < STEPS; s++) begin
                for (int k = 0; k < 8; k++) begin
                    v = gf_mulx(v, MAX_W'(POLY), CRC_W);
                end
                t[s][b] = v[CRC_W-1:0];
            end
        end
        return t;
    endfunction

    localparam adv_tab_t ADV = build_adv();

    logic [SEL_W-1:0] idx;

    always_comb begin
        if (nbytes == '0 || nbytes > SEL_W'(STEPS)) begin
            idx = SEL_W'(STEPS - 1);
        end else begin
            idx = nbytes - SEL_W'(1);
        end
        res = '0;
        for (int b = 0; b < CRC_W; b++) begin
            if (rem[b]) begin
                res = res ^ ADV[idx][b];
            end
        end
    end

endmodule

// File: rtl/crc_wide_align.sv
module crc_wide_align #(
    parameter int  DATA_W = 256,
    localparam int BYTES  = DATA_W / 8,
    localparam int CNT_W  = $clog2(BYTES) + 1
) (
    input  logic [DATA_W-1:0] word,
    input  logic [CNT_W-1:0]  nbytes,
    output logic [DATA_W-1:0] aligned
);
    logic [CNT_W-1:0] drop;

    always_comb begin
        drop    = CNT_W'(BYTES) - nbytes;
        aligned = word >> {drop, 3'b000};
    end

endmodule

// File: rtl/crc_wide_pipe.sv
module crc_wide_pipe
    import crc_wide_pkg::*;
#(
    parameter int               DATA_W = 256,
    parameter int               CRC_W  = 32,
    parameter logic [CRC_W-1:0] POLY   = 32'h04C11DB7,
    localparam int              BYTES  = DATA_W / 8,
    localparam int              LEN_W  = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic              in_end,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LEN_W-1:0]  in_len,
    output logic [CRC_W-1:0]  crc_out,
    output logic              crc_done
);
    localparam int CHUNKS = DATA_W / CRC_W;
    localparam int CNT_W  = LEN_W + 1;

    // ---------------- stage 0: word contribution, no feedback ----------------
    logic [CNT_W-1:0]             len_eff;
    logic [DATA_W-1:0]            word_al;
    logic [CHUNKS-1:0][CRC_W-1:0] chunk_part;
    logic [CRC_W-1:0]             word_rem;

    always_comb begin
        if (in_end && in_len != '0) begin
            len_eff = CNT_W'(in_len);
        end else begin
            len_eff = CNT_W'(BYTES);
        end
    end

    crc_wide_align #(.DATA_W(DATA_W)) u_align (
        .word    (in_data),
        .nbytes  (len_eff),
        .aligned (word_al)
    );

    for (genvar k = 0; k < CHUNKS; k++) begin : g_chunk
        crc_wide_fold #(
            .CRC_W (CRC_W),
            .POLY  (POLY),
            .POS   (k * CRC_W)
        ) u_fold (
            .chunk (word_al[k*CRC_W +: CRC_W]),
            .part  (chunk_part[k])
        );
    end

    always_comb begin
        word_rem = '0;
        for (int k = 0; k < CHUNKS; k++) begin
            word_rem = word_rem ^ chunk_part[k];
        end
    end

    logic             s1_valid, s1_start, s1_end;
    logic [CNT_W-1:0] s1_len;
    logic [CRC_W-1:0] s1_rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_start <= 1'b0;
            s1_end   <= 1'b0;
            s1_len   <= '0;
            s1_rem   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_start <= in_start;
                s1_end   <= in_end;
                s1_len   <= len_eff;
                s1_rem   <= word_rem;
            end
        end
    end

    // ---------------- stage 1: remainder loop and message controller ----------
    msg_state_e       state_q, state_d;
    logic [CRC_W-1:0] acc_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] base_adv;
    logic             accept;

    assign base   = s1_start ? '0 : acc_q;
    assign accept = s1_valid && (s1_start || state_q == ST_BUSY);

    crc_wide_advance #(
        .CRC_W (CRC_W),
        .POLY  (POLY),
        .STEPS (BYTES)
    ) u_step (
        .rem    (base),
        .nbytes (CNT_W'(BYTES)),
        .res    (base_adv)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (s1_valid && s1_start && !s1_end) state_d = ST_BUSY;
            ST_BUSY: if (s1_valid && s1_end)              state_d = ST_IDLE;
            default:                                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    logic             s2_valid;
    logic [CRC_W-1:0] s2_base;
    logic [CNT_W-1:0] s2_len;
    logic [CRC_W-1:0] s2_rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            s2_valid <= 1'b0;
            s2_base  <= '0;
            s2_len   <= '0;
            s2_rem   <= '0;
        end else begin
            s2_valid <= accept && s1_end;
            if (accept && !s1_end) begin
                acc_q <= base_adv ^ s1_rem;
            end
            if (accept && s1_end) begin
                s2_base <= base;
                s2_len  <= s1_len;
                s2_rem  <= s1_rem;
            end
        end
    end

    // ---------------- stage 2: variable tail advance and outputs --------------
    logic [CRC_W-1:0] tail_adv;

    crc_wide_advance #(
        .CRC_W (CRC_W),
        .POLY  (POLY),
        .STEPS (BYTES)
    ) u_tail (
        .rem    (s2_base),
        .nbytes (s2_len),
        .res    (tail_adv)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_out  <= '0;
            crc_done <= 1'b0;
        end else begin
            crc_done <= s2_valid;
            if (s2_valid) begin
                crc_out <= tail_adv ^ s2_rem;
            end
        end
    end

endmodule

// File: rtl/crc_wide_pipe_chk.sv
module crc_wide_pipe_chk
    import crc_wide_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int CRC_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_start,
    input logic              in_end,
    input logic [DATA_W-1:0] in_data,
    input logic [CRC_W-1:0]  crc_out,
    input logic              crc_done,
    input msg_state_e        state
);
    logic [1:0] age_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign warm = (age_q == 2'd3);

    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done |-> $past(in_valid && in_end, 3)); // R7

    AST_DONE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done |-> ($past(in_start, 3) || $past(state, 2) == ST_BUSY)); // R6

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !crc_done) |-> $stable(crc_out)); // R8

    AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid && in_start && in_end && in_data == '0, 3))
        |-> (crc_done && crc_out == '0)); // R4

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!crc_done && crc_out == '0 && state == ST_IDLE)); // R10

endmodule

bind crc_wide_pipe crc_wide_pipe_chk #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_end   (in_end),
    .in_data  (in_data),
    .crc_out  (crc_out),
    .crc_done (crc_done),
    .state    (state_q)
);

// File: tb/crc_wide_pipe_tb_top.sv
module crc_wide_pipe_tb_top;

    localparam int               DATA_W = 256;
    localparam int               CRC_W  = 32;
    localparam int               BYTES  = DATA_W / 8;
    localparam int               LEN_W  = $clog2(BYTES);
    localparam logic [CRC_W-1:0] POLY   = 32'h04C11DB7;

    typedef logic [7:0] bq_t[$];

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_start = 1'b0;
    logic              in_end = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic [CRC_W-1:0]  crc_out;
    logic              crc_done;

    crc_wide_pipe #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_start (in_start),
        .in_end   (in_end),
        .in_data  (in_data),
        .in_len   (in_len),
        .crc_out  (crc_out),
        .crc_done (crc_done)
    );

    always #4ns clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    logic [CRC_W-1:0] exp_crc_q[$];
    int               exp_due_q[$];
    string            exp_tag_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [CRC_W-1:0] ref_crc(input bq_t m);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = '0;
        foreach (m[i]) begin
            for (int b = 7; b >= 0; b--) begin
                fb = r[CRC_W-1] ^ m[i][b];
                r  = r << 1;
                if (fb) r = r ^ POLY;
            end
        end
        return r;
    endfunction

    function automatic bq_t mk(input int len, input int seed);
        bq_t q;
        for (int i = 0; i < len; i++) begin
            q.push_back(8'((i * 37 + seed * 11 + (i >> 3) * 5) ^ (seed * 3)));
        end
        return q;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_start = 1'b1;
            in_end   = 1'b1;
            in_data  = {8{$urandom}};
            in_len   = LEN_W'($urandom);
        end
    endtask

    // Driver: splits a message into words and pushes the expected result.
    task automatic send_msg(input bq_t m, input int gap, input logic [CRC_W-1:0] exp_crc,
                            input string tag);
        int nw;
        nw = (m.size() + BYTES - 1) / BYTES;
        for (int w = 0; w < nw; w++) begin
            logic [DATA_W-1:0] d;
            int                cnt;
            cnt = m.size() - w * BYTES;
            if (cnt > BYTES) cnt = BYTES;
            d = {8{$urandom}};
            for (int i = 0; i < cnt; i++) d[DATA_W-1-8*i -: 8] = m[w*BYTES+i];
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (w == 0);
            in_end   = (w == nw - 1);
            in_data  = d;
            in_len   = LEN_W'(cnt);
            if (w == nw - 1) begin
                exp_crc_q.push_back(exp_crc);
                exp_due_q.push_back(cyc + 3);
                exp_tag_q.push_back(tag);
            end else if (gap > 0) begin
                idle(gap);
            end
        end
    endtask

    // Opens a message and never closes it.
    task automatic send_open(input int nwords, input int seed);
        for (int w = 0; w < nwords; w++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (w == 0);
            in_end   = 1'b0;
            in_data  = {8{$urandom}} ^ DATA_W'(seed);
            in_len   = '0;
        end
    endtask

    // Monitor: pops the scoreboard as results appear.
    initial begin
        logic [CRC_W-1:0] last_crc;
        logic [CRC_W-1:0] e;
        int               due;
        string            tag;
        last_crc = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (crc_done) begin
                    if (exp_crc_q.size() == 0) begin
                        check(1'b0, "R6", "unexpected done", crc_out, 32'h0);
                    end else begin
                        e   = exp_crc_q.pop_front();
                        due = exp_due_q.pop_front();
                        tag = exp_tag_q.pop_front();
                        check(crc_out == e, tag, "crc value", crc_out, e);
                        check(cyc == due, "R7", "done cycle", 32'(cyc), 32'(due));
                    end
                    last_crc = crc_out;
                end else begin
                    check(crc_out == last_crc, "R8", "crc held", crc_out, last_crc);
                    if (exp_due_q.size() > 0 && cyc > exp_due_q[0]) begin
                        check(1'b0, "R7", "missing done", 32'(cyc), 32'(exp_due_q[0]));
                        void'(exp_crc_q.pop_front());
                        void'(exp_due_q.pop_front());
                        void'(exp_tag_q.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bq_t one;
        repeat (3) @(negedge clk);
        check(crc_done == 1'b0, "R10", "done in reset", 32'(crc_done), 32'h0);
        check(crc_out == '0, "R10", "crc in reset", crc_out, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1: hand-known value and modelled values
        one.push_back(8'h01);
        send_msg(one, 0, 32'h04C11DB7, "R1");
        send_msg(mk(9, 1), 0, ref_crc(mk(9, 1)), "R1");
        send_msg(mk(4, 2), 0, ref_crc(mk(4, 2)), "R1");
        idle(3);

        // R3: tail lengths around chunk and word boundaries
        send_msg(mk(3, 3), 0, ref_crc(mk(3, 3)), "R3");
        send_msg(mk(5, 4), 0, ref_crc(mk(5, 4)), "R3");
        send_msg(mk(31, 5), 0, ref_crc(mk(31, 5)), "R3");
        send_msg(mk(32, 6), 0, ref_crc(mk(32, 6)), "R3");
        send_msg(mk(33, 7), 0, ref_crc(mk(33, 7)), "R3");
        send_msg(mk(66, 8), 0, ref_crc(mk(66, 8)), "R3");
        send_msg(mk(99, 9), 0, ref_crc(mk(99, 9)), "R3");

        // R2: long messages back to back
        send_msg(mk(200, 10), 0, ref_crc(mk(200, 10)), "R2");
        send_msg(mk(64, 11), 0, ref_crc(mk(64, 11)), "R2");
        idle(4);

        // R9: gaps inside a message with hostile idle inputs
        send_msg(mk(100, 12), 2, ref_crc(mk(100, 12)), "R9");
        send_msg(mk(67, 13), 1, ref_crc(mk(67, 13)), "R9");
        idle(3);

        // R5: abandoned message, then a new one
        send_open(2, 14);
        send_msg(mk(40, 15), 0, ref_crc(mk(40, 15)), "R5");
        send_open(1, 16);
        send_msg(mk(2, 17), 0, ref_crc(mk(2, 17)), "R5");
        idle(3);

        // R4: all-zero single word, then a message right after it
        send_msg(mk(0, 0), 0, 32'h0, "R4");
        idle(1);
        begin
            bq_t z;
            for (int i = 0; i < BYTES; i++) z.push_back(8'h00);
            send_msg(z, 0, 32'h0, "R4");
        end
        send_msg(mk(45, 18), 0, ref_crc(mk(45, 18)), "R4");
        idle(3);

        // R6: stray words while no message is open
        @(negedge clk);
        in_valid = 1'b1; in_start = 1'b0; in_end = 1'b1; in_data = {8{$urandom}}; in_len = '0;
        @(negedge clk);
        in_valid = 1'b1; in_start = 1'b0; in_end = 1'b0; in_data = {8{$urandom}}; in_len = '0;
        idle(6);
        send_msg(mk(36, 19), 0, ref_crc(mk(36, 19)), "R6");
        idle(10);

        check(exp_crc_q.size() == 0, "R2", "pending results", 32'(exp_crc_q.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule